// File: doc/BRIEF.md
# Event Timestamp Capture Queue

This block stores hardware timestamps of time-synchronisation event messages for one network port. When the frame logic upstream sees an event message, it pulses a capture strobe together with the message's tag, a 48-bit seconds value, a 32-bit nanoseconds value, a 64-bit clock identity, a 16-bit port number and a 16-bit sequence ID. The block packs these values into one record and appends it to a first-in first-out store of up to 90 records.

Software drains the store through a single 16-bit data register. Each record comes out as twelve words. Every read of the data register moves a read-position counter forward, and the last word of a record removes that record. A status register shows the capture enable, the read position and a saturating count of captures lost because the store was full. A separate flag says whether any record is waiting. The data and status outputs are combinational views of the internal registers, so their values are valid in the cycle before the clock edge that consumes a read.

Top module: `ts_capture_fifo`

## Requirements
- R1: A record is delivered as 12 words in this sequence: the tag (bits 2:0 give the message type: 1 Sync, 2 Pdelay_Req, 3 Pdelay_Resp, 4 Delay_Req), then seconds in 3 words, then nanoseconds in 2 words, then clock identity in 4 words, then the port number, then the sequence ID.
- R2: In every field that takes more than one word, the most significant 16 bits come first. Shifting the result left by 16 and ORing in each new word rebuilds the value.
- R3: `stat_rdata` has the capture enable at bit 15, the read position at bits 12:8 and the discard count at bits 7:4. All other bits read zero.
- R4: The read position is 0 when the next word to be read is a tag. Each `data_rd` on a non-empty store adds one to it. The read that returns word 12 sets it back to 0 and removes the record.
- R5: `not_empty` is high exactly when at least one record is held.
- R6: The store holds 90 records. A capture strobe that arrives while the store is full is dropped and increments the discard count, which saturates at 15. Fullness is judged on the state before the clock edge, even if a record is removed on that same edge.
- R7: A pulse on `stat_wr` loads the enable from `stat_wdata` bit 15 and clears the discard count. The clear wins over a drop that happens on the same edge.
- R8: No record is stored while the enable is clear.
- R9: While the store is empty, `data_rdata` reads zero and a `data_rd` leaves the read position at zero.
- R10: After reset the store is empty, the enable is clear and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_strobe | input | 1 | Capture pulse for one event |
| cap_tag | input | 16 | Event tag (message type in bits 2:0) |
| cap_sec | input | 48 | Seconds part of the timestamp |
| cap_nsec | input | 32 | Nanoseconds part of the timestamp |
| cap_clkid | input | 64 | Source clock identity |
| cap_portnum | input | 16 | Source port number |
| cap_seqid | input | 16 | Sequence ID |
| stat_wr | input | 1 | Write pulse for the status register |
| stat_wdata | input | 16 | Status write data (bit 15 = enable) |
| stat_rdata | output | 16 | Status register view |
| data_rd | input | 1 | Read pulse for the data register |
| data_rdata | output | 16 | Word at the current read position |
| not_empty | output | 1 | At least one record is held |

## Verification
The assertions assume that `data_rd`, `stat_wr` and `cap_strobe` are single-cycle pulses sampled on the rising edge. They also assume that software samples `data_rdata` in the same cycle as its read pulse. They allow reads on an empty store, captures while disabled, and captures while full, because these are defined cases and not misuse. The stimulus changes every input only on the falling edge. It fills the store past its limit, reads while empty, and writes the status register while records are still being dropped. This keeps each of those cases inside the behaviour that the properties describe.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int WORD_W    = 16;
  localparam int REC_WORDS = 12;
  localparam int REC_W     = WORD_W * REC_WORDS;
  localparam int POS_W     = 5;
  localparam int DISC_W    = 4;

  typedef logic [REC_W-1:0] rec_t;

  // Lay the fields out so that word 0 is the most significant slice.
  function automatic rec_t rec_pack(input logic [15:0] tag, input logic [47:0] sec,
                                    input logic [31:0] nsec, input logic [63:0] clkid,
                                    input logic [15:0] portnum, input logic [15:0] seqid);
    return {tag, sec, nsec, clkid, portnum, seqid};
  endfunction

  // Pick word idx (0 = first delivered) out of a packed record.
  function automatic logic [WORD_W-1:0] rec_word(input rec_t r, input logic [POS_W-1:0] idx);
    rec_t sh;
    sh = r >> (WORD_W * (REC_WORDS - 1 - int'(idx)));
    return sh[WORD_W-1:0];
  endfunction

  function automatic logic [POS_W-1:0] pos_next(input logic [POS_W-1:0] p);
    return (p == POS_W'(REC_WORDS - 1)) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/tsf_store.sv
module tsf_store
  import tsf_pkg::*;
#(
  parameter int DEPTH = 90,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  rec_t             wrec,
  output rec_t             head,
  output logic             full,
  output logic             empty,
  output logic [OCC_W-1:0] occ
);
  rec_t mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wrec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push) wptr <= ptr_inc(wptr);
      if (pop)  rptr <= ptr_inc(rptr);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign full  = (occ == OCC_W'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_strobe,
  input  logic              data_rd,
  input  logic              stat_wr,
  input  logic              stat_en_bit,
  input  logic              full,
  input  logic              empty,
  output logic              push,
  output logic              pop,
  output logic              drop,
  output logic              en_q,
  output logic [POS_W-1:0]  pos_q,
  output logic [DISC_W-1:0] disc_q
);
  logic word_rd;
  logic last_word;

  assign word_rd   = data_rd & ~empty;
  assign last_word = (pos_q == POS_W'(REC_WORDS - 1));
  assign push      = cap_strobe & en_q & ~full;
  assign drop      = cap_strobe & en_q & full;
  assign pop       = word_rd & last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pos_q  <= '0;
      disc_q <= '0;
    end else begin
      if (word_rd) pos_q <= pos_next(pos_q);
      if (stat_wr) begin
        en_q   <= stat_en_bit;
        disc_q <= '0;
      end else if (drop && disc_q != '1) begin
        disc_q <= disc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ts_capture_fifo.sv
module ts_capture_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH = 90
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_strobe,
  input  logic [15:0] cap_tag,
  input  logic [47:0] cap_sec,
  input  logic [31:0] cap_nsec,
  input  logic [63:0] cap_clkid,
  input  logic [15:0] cap_portnum,
  input  logic [15:0] cap_seqid,
  input  logic        stat_wr,
  input  logic [15:0] stat_wdata,
  output logic [15:0] stat_rdata,
  input  logic        data_rd,
  output logic [15:0] data_rdata,
  output logic        not_empty
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic              push, pop, drop;
  logic              full_w, empty_w;
  logic              en_q;
  logic [POS_W-1:0]  rd_pos;
  logic [DISC_W-1:0] disc_cnt;
  logic [OCC_W-1:0]  occ;
  rec_t              head_rec, new_rec;

  assign new_rec = rec_pack(cap_tag, cap_sec, cap_nsec, cap_clkid, cap_portnum, cap_seqid);

  tsf_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wrec  (new_rec),
    .head  (head_rec),
    .full  (full_w),
    .empty (empty_w),
    .occ   (occ)
  );

  tsf_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_strobe  (cap_strobe),
    .data_rd     (data_rd),
    .stat_wr     (stat_wr),
    .stat_en_bit (stat_wdata[15]),
    .full        (full_w),
    .empty       (empty_w),
    .push        (push),
    .pop         (pop),
    .drop        (drop),
    .en_q        (en_q),
    .pos_q       (rd_pos),
    .disc_q      (disc_cnt)
  );

  assign stat_rdata = {en_q, 2'b00, rd_pos, disc_cnt, 4'b0000};
  assign data_rdata = empty_w ? '0 : rec_word(head_rec, rd_pos);
  assign not_empty  = ~empty_w;
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int DEPTH = 90,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_strobe,
  input logic             stat_wr,
  input logic             data_rd,
  input logic             drop,
  input logic             en_q,
  input logic [4:0]       rd_pos,
  input logic [3:0]       disc_cnt,
  input logic [OCC_W-1:0] occ,
  input logic             full_w,
  input logic             not_empty,
  input logic [15:0]      data_rdata
);
  AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pos <= 5'd11); // R4
  AST_MID_RECORD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && not_empty && rd_pos != 5'd11) |=> occ >= $past(occ)); // R4
  AST_EMPTY_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> rd_pos == 5'd0); // R9
  AST_EMPTY_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> data_rdata == 16'h0); // R9
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)); // R6
  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_w && cap_strobe && en_q && !stat_wr && disc_cnt != 4'hf) |=> disc_cnt == $past(disc_cnt) + 4'd1); // R6
  AST_DISC_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_cnt == 4'hf && !stat_wr) |=> disc_cnt == 4'hf); // R6
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> full_w); // R6
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> disc_cnt == 4'h0); // R7
  AST_OFF_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || !cap_strobe) |=> occ <= $past(occ)); // R8
endmodule

bind ts_capture_fifo tsf_checker #(.DEPTH(DEPTH)) u_tsf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_strobe (cap_strobe),
  .stat_wr    (stat_wr),
  .data_rd    (data_rd),
  .drop       (drop),
  .en_q       (en_q),
  .rd_pos     (rd_pos),
  .disc_cnt   (disc_cnt),
  .occ        (occ),
  .full_w     (full_w),
  .not_empty  (not_empty),
  .data_rdata (data_rdata)
);

// File: tb/ts_capture_fifo_bench.sv
module ts_capture_fifo_bench;
  localparam int DEPTH = 90;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_strobe = 1'b0;
  logic [15:0] cap_tag = '0;
  logic [47:0] cap_sec = '0;
  logic [31:0] cap_nsec = '0;
  logic [63:0] cap_clkid = '0;
  logic [15:0] cap_portnum = '0;
  logic [15:0] cap_seqid = '0;
  logic        stat_wr = 1'b0;
  logic [15:0] stat_wdata = '0;
  logic [15:0] stat_rdata;
  logic        data_rd = 1'b0;
  logic [15:0] data_rdata;
  logic        not_empty;

  always #4 clk = ~clk;

  ts_capture_fifo #(.DEPTH(DEPTH)) u_ts_capture_fifo (.*);

  // behavioural reference state
  logic [191:0] mq[$];
  int  m_pos = 0;
  int  m_disc = 0;
  bit  m_en = 0;
  int  total = 0;
  int  bad = 0;
  logic [15:0] seen;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_word();
    logic [191:0] r;
    if (mq.size() == 0) return 16'h0;
    r = mq[0];
    return r[191 - 16*m_pos -: 16];
  endfunction

  // compare before the edge, then advance the model with the same inputs
  task automatic step();
    #1;
    seen = data_rdata;
    chk(32'(data_rdata), 32'(m_word()), "R1 word");
    chk(32'(stat_rdata), 32'({m_en, 2'b00, 5'(m_pos), 4'(m_disc), 4'b0}), "R3 status");
    chk(32'(not_empty), 32'(mq.size() != 0), "R5 flag");
    @(posedge clk);
    begin
      int sz = mq.size();
      if (cap_strobe && m_en) begin
        if (sz == DEPTH) begin
          if (m_disc < 15) m_disc++;
        end else mq.push_back({cap_tag, cap_sec, cap_nsec, cap_clkid, cap_portnum, cap_seqid});
      end
      if (data_rd && sz > 0) begin
        if (m_pos == 11) begin void'(mq.pop_front()); m_pos = 0; end
        else m_pos++;
      end
      if (stat_wr) begin m_en = stat_wdata[15]; m_disc = 0; end
    end
    @(negedge clk);
    cap_strobe = 0; data_rd = 0; stat_wr = 0;
  endtask

  task automatic set_cap(input int n);
    cap_strobe  = 1;
    cap_tag     = {13'(n), 3'(n % 4 + 1)};
    cap_sec     = 48'h0a0b_0000_0000 + 48'(n) * 48'h1_0001_0001;
    cap_nsec    = 32'h3000_0000 + 32'(n) * 32'h0001_0003;
    cap_clkid   = 64'h1122_3344_5566_7788 ^ 64'(n);
    cap_portnum = 16'(n + 7);
    cap_seqid   = 16'(n * 3);
  endtask

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] acc;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    chk(32'(stat_rdata), 32'h0, "R10 reset status");
    chk(32'(not_empty), 32'h0, "R10 reset empty");
    chk(32'(data_rdata), 32'h0, "R10 reset data");
    @(negedge clk);

    // R8: disabled capture stores nothing
    set_cap(1); step();
    #1 chk(32'(not_empty), 32'h0, "R8 no store when disabled");
    @(negedge clk);

    stat_wr = 1; stat_wdata = 16'h8000; step();
    for (int i = 0; i < 3; i++) begin set_cap(10 + i); step(); end

    // R1 R2: rebuild fields from words
    data_rd = 1; step();
    chk(32'(seen[2:0]), 32'(10 % 4 + 1), "R1 tag type");
    acc = '0;
    for (int i = 0; i < 3; i++) begin data_rd = 1; step(); acc = (acc << 16) | 48'(seen); end
    chk(32'(acc[47:16]), 32'((48'h0a0b_0000_0000 + 48'd10 * 48'h1_0001_0001) >> 16), "R2 seconds high");
    chk(32'(acc[15:0]), 32'(16'(48'h0a0b_0000_0000 + 48'd10 * 48'h1_0001_0001)), "R2 seconds low");
    #1 chk(32'(stat_rdata[12:8]), 32'd4, "R4 position mid record");
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin data_rd = 1; step(); end
    chk(32'(seen), 32'(16'(10 * 3)), "R1 last word seqid");
    #1 chk(32'(stat_rdata[12:8]), 32'd0, "R4 wrap after twelfth word");
    @(negedge clk);

    // drain rest, then read while empty
    for (int i = 0; i < 24; i++) begin data_rd = 1; step(); end
    data_rd = 1; step();
    chk(32'(seen), 32'h0, "R9 empty read zero");
    #1 chk(32'(stat_rdata[12:8]), 32'd0, "R9 position unchanged");
    @(negedge clk);

    // R6: fill, overflow, saturate
    for (int i = 0; i < DEPTH + 18; i++) begin set_cap(100 + i); step(); end
    #1 chk(32'(stat_rdata[7:4]), 32'd15, "R6 discard saturates");
    @(negedge clk);
    // full + pop on the same edge: capture still dropped; clear wins (R7)
    data_rd = 1; step();
    for (int i = 0; i < 10; i++) begin data_rd = 1; step(); end
    set_cap(500); data_rd = 1; stat_wr = 1; stat_wdata = 16'h8000; step();
    #1 chk(32'(stat_rdata[7:4]), 32'd0, "R7 clear wins over drop");
    @(negedge clk);
    set_cap(501); step();
    #1 chk(32'(stat_rdata[7:4]), 32'd0, "R6 space after pop");
    @(negedge clk);

    // drain everything
    while (mq.size() > 0) begin data_rd = 1; step(); end
    #1 chk(32'(not_empty), 32'h0, "R5 empty after drain");
    @(negedge clk);
    stat_wr = 1; stat_wdata = 16'h0; step();
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule